// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a 16-bit NOR-style flash memory model. It watches write bus cycles, each one an address plus a data word, sampled on a synchronous write strobe. It recognises the fixed-length unlock sequences that start embedded operations. When a sequence completes, it sends a one-cycle request to the array engine: program a word, erase the whole chip, erase one sector, or turn on the boot-area lockout. The storage array, the erase and program timing, and status reporting all live outside this block.

The decoder also holds a persistent identification mode. A three-cycle sequence enters it. Either a three-cycle sequence or a lone exit code written to any address leaves it. While the engine reports that it is busy, the decoder ignores every write and keeps its place in any partial sequence. A write that does not fit the current step of a sequence drops the decoder back to idle, and that write is not then treated as the start of a new sequence.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A multi-cycle command begins only with data AA at address 05555h followed by data 55 at address 02AAAh. A wrong address or a wrong code in either cycle produces no request.
- R2: After the unlock pair, writing A0 at 05555h makes the next write a program cycle. One cycle after that write, prog_o pulses and op_addr_o and op_data_o hold its address and full 16-bit data.
- R3: The erase prefix is unlock, 80 at 05555h, then unlock again. A sixth write of 10 at 05555h pulses chip_erase_o one cycle later. Code 10 at any other address issues nothing.
- R4: After the erase prefix, a sixth write of 30 at any address pulses sect_erase_o one cycle later, with op_addr_o equal to that address.
- R5: After the erase prefix, a sixth write of 40 at 05555h pulses lock_en_o one cycle later.
- R6: Unlock followed by 90 at 05555h sets id_mode_o one cycle later. The bit stays set through later unrelated writes.
- R7: id_mode_o clears one cycle after either of two exits: unlock followed by F0 at 05555h, or a single F0 written to any address while no sequence is in progress.
- R8: Command cycles decode only data bits 7..0, and bits 15..8 do not affect them. The program data cycle keeps all 16 bits.
- R9: While busy_i is high, writes produce no request, do not change id_mode_o, and do not disturb a partly entered sequence.
- R10: A write that breaks a sequence returns the decoder to idle and is not re-evaluated. An AA at 05555h in step two does not restart the sequence, and an F0 in step two does not leave identification mode.
- R11: While rst_ni is low, and right after it rises, all request pulses are low, id_mode_o is low and the decoder is idle.
- R12: At most one request pulse is high in any cycle, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one bus write per cycle it is high |
| wr_addr_i | input | AW (18) | Write address |
| wr_data_i | input | DW (16) | Write data |
| busy_i | input | 1 | Engine busy, writes are ignored |
| prog_o | output | 1 | Word program request pulse |
| chip_erase_o | output | 1 | Chip erase request pulse |
| sect_erase_o | output | 1 | Sector erase request pulse |
| lock_en_o | output | 1 | Boot lockout enable request pulse |
| op_addr_o | output | AW (18) | Target address for program or sector erase |
| op_data_o | output | DW (16) | Data word for program |
| id_mode_o | output | 1 | Identification mode active |

## Verification
The bench goes after broken sequences. It replays an unlock byte in the second step, which a decoder that restarts on the offending write would turn into a spurious program request. It also writes an exit code mid-sequence, which a careless design would let drop identification mode. Command writes carry junk in the upper data byte, which catches a comparator that looks at all 16 bits. Busy-time writes are placed in the middle of a program sequence, which exposes a design that resets or advances its step under busy. Erase sixth cycles are sent with the right code at the wrong address, which exposes a design that ignores the address check for chip erase or lockout.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CODE_FIRST  = 8'hAA;
  localparam logic [7:0] CODE_SECOND = 8'h55;
  localparam logic [7:0] CODE_PROG   = 8'hA0;
  localparam logic [7:0] CODE_ERASE  = 8'h80;
  localparam logic [7:0] CODE_CHIP   = 8'h10;
  localparam logic [7:0] CODE_SECT   = 8'h30;
  localparam logic [7:0] CODE_LOCK   = 8'h40;
  localparam logic [7:0] CODE_ID_ON  = 8'h90;
  localparam logic [7:0] CODE_ID_OFF = 8'hF0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PROG,
    ST_ERS3,
    ST_ERS4,
    ST_ERS5
  } seq_state_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_PROG,
    EV_CHIP,
    EV_SECT,
    EV_LOCK,
    EV_ID_ON,
    EV_ID_OFF
  } cmd_event_e;

  typedef struct packed {
    logic       at_cmd;
    logic       at_alt;
    logic [7:0] code;
  } cyc_info_t;

endpackage

// File: rtl/fcd_cycle_class.sv
module fcd_cycle_class
  import flash_cmd_pkg::*;
#(
  parameter int unsigned    AW       = 18,
  parameter logic [AW-1:0] CMD_ADDR = 18'h05555,
  parameter logic [AW-1:0] ALT_ADDR = 18'h02AAA
) (
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    code_i,
  output cyc_info_t     info_o
);

  always_comb begin
    info_o.at_cmd = (addr_i == CMD_ADDR);
    info_o.at_alt = (addr_i == ALT_ADDR);
    info_o.code   = code_i;
  end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import flash_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  cyc_info_t  info_i,
  output cmd_event_e event_o
);

  seq_state_e state_q, state_d;
  logic first_ok, second_ok;

  assign first_ok  = info_i.at_cmd && (info_i.code == CODE_FIRST);
  assign second_ok = info_i.at_alt && (info_i.code == CODE_SECOND);

  always_comb begin
    state_d = state_q;
    event_o = EV_NONE;
    if (strobe_i) begin
      // any mismatch falls to idle without re-evaluating the cycle
      state_d = ST_IDLE;
      unique case (state_q)
        ST_IDLE: begin
          if (first_ok)                        state_d = ST_UNL1;
          else if (info_i.code == CODE_ID_OFF) event_o = EV_ID_OFF;
        end
        ST_UNL1: if (second_ok) state_d = ST_UNL2;
        ST_UNL2: begin
          if (info_i.at_cmd) begin
            case (info_i.code)
              CODE_PROG:   state_d = ST_PROG;
              CODE_ERASE:  state_d = ST_ERS3;
              CODE_ID_ON:  event_o = EV_ID_ON;
              CODE_ID_OFF: event_o = EV_ID_OFF;
              default:     state_d = ST_IDLE;
            endcase
          end
        end
        ST_PROG: event_o = EV_PROG;
        ST_ERS3: if (first_ok)  state_d = ST_ERS4;
        ST_ERS4: if (second_ok) state_d = ST_ERS5;
        ST_ERS5: begin
          if (info_i.code == CODE_SECT)                        event_o = EV_SECT;
          else if (info_i.at_cmd && info_i.code == CODE_CHIP)  event_o = EV_CHIP;
          else if (info_i.at_cmd && info_i.code == CODE_LOCK)  event_o = EV_LOCK;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/fcd_issue.sv
module fcd_issue
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW = 18,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cmd_event_e    event_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          prog_o,
  output logic          chip_erase_o,
  output logic          sect_erase_o,
  output logic          lock_en_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_data_o,
  output logic          id_mode_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_o       <= 1'b0;
      chip_erase_o <= 1'b0;
      sect_erase_o <= 1'b0;
      lock_en_o    <= 1'b0;
      op_addr_o    <= '0;
      op_data_o    <= '0;
      id_mode_o    <= 1'b0;
    end else begin
      prog_o       <= (event_i == EV_PROG);
      chip_erase_o <= (event_i == EV_CHIP);
      sect_erase_o <= (event_i == EV_SECT);
      lock_en_o    <= (event_i == EV_LOCK);
      if (event_i == EV_PROG || event_i == EV_SECT) op_addr_o <= addr_i;
      if (event_i == EV_PROG)                       op_data_o <= data_i;
      if (event_i == EV_ID_ON)       id_mode_o <= 1'b1;
      else if (event_i == EV_ID_OFF) id_mode_o <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned    AW       = 18,
  parameter int unsigned    DW       = 16,
  parameter logic [AW-1:0] CMD_ADDR = 18'h05555,
  parameter logic [AW-1:0] ALT_ADDR = 18'h02AAA
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          busy_i,
  output logic          prog_o,
  output logic          chip_erase_o,
  output logic          sect_erase_o,
  output logic          lock_en_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_data_o,
  output logic          id_mode_o
);

  cyc_info_t  info;
  cmd_event_e evt;
  logic       strobe;

  assign strobe = wr_en_i && !busy_i;

  fcd_cycle_class #(
    .AW(AW), .CMD_ADDR(CMD_ADDR), .ALT_ADDR(ALT_ADDR)
  ) u_class (
    .addr_i (wr_addr_i),
    .code_i (wr_data_i[7:0]),
    .info_o (info)
  );

  fcd_seq_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe),
    .info_i   (info),
    .event_o  (evt)
  );

  fcd_issue #(.AW(AW), .DW(DW)) u_issue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .event_i      (evt),
    .addr_i       (wr_addr_i),
    .data_i       (wr_data_i),
    .prog_o       (prog_o),
    .chip_erase_o (chip_erase_o),
    .sect_erase_o (sect_erase_o),
    .lock_en_o    (lock_en_o),
    .op_addr_o    (op_addr_o),
    .op_data_o    (op_data_o),
    .id_mode_o    (id_mode_o)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int unsigned    AW       = 18,
  parameter int unsigned    DW       = 16,
  parameter logic [AW-1:0] CMD_ADDR = 18'h05555
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic          busy_i,
  input logic          prog_o,
  input logic          chip_erase_o,
  input logic          sect_erase_o,
  input logic          lock_en_o,
  input logic [AW-1:0] op_addr_o,
  input logic [DW-1:0] op_data_o,
  input logic          id_mode_o
);

  logic any_pulse;
  assign any_pulse = prog_o | chip_erase_o | sect_erase_o | lock_en_o;

  a_r12_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_o, chip_erase_o, sect_erase_o, lock_en_o}));

  a_r12_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_pulse |=> !any_pulse);

  a_r9_idle_or_busy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i || !wr_en_i) |=> (!any_pulse && $stable(id_mode_o)));

  a_r2_prog_payload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |-> (op_addr_o == $past(wr_addr_i) && op_data_o == $past(wr_data_i)));

  a_r3_chip_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_erase_o |-> ($past(wr_addr_i) == CMD_ADDR && $past(wr_data_i[7:0]) == 8'h10));

  a_r4_sect_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sect_erase_o |-> ($past(wr_data_i[7:0]) == 8'h30 && op_addr_o == $past(wr_addr_i)));

  a_r5_lock_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_en_o |-> ($past(wr_addr_i) == CMD_ADDR && $past(wr_data_i[7:0]) == 8'h40));

  a_r6_id_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(id_mode_o) |-> ($past(wr_data_i[7:0]) == 8'h90 && $past(wr_addr_i) == CMD_ADDR));

  a_r7_id_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(id_mode_o) |-> ($past(wr_data_i[7:0]) == 8'hF0));

endmodule

bind flash_cmd_decoder fcd_checker #(
  .AW(AW), .DW(DW), .CMD_ADDR(CMD_ADDR)
) u_fcd_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .busy_i       (busy_i),
  .prog_o       (prog_o),
  .chip_erase_o (chip_erase_o),
  .sect_erase_o (sect_erase_o),
  .lock_en_o    (lock_en_o),
  .op_addr_o    (op_addr_o),
  .op_data_o    (op_data_o),
  .id_mode_o    (id_mode_o)
);

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;

  localparam int AW = 18;
  localparam int DW = 16;
  localparam logic [AW-1:0] A1 = 18'h05555;
  localparam logic [AW-1:0] A2 = 18'h02AAA;
  localparam int K_PROG = 1, K_CHIP = 2, K_SECT = 3, K_LOCK = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, busy = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic prog, chip, sect, lock, idm;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    int            kind;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  flash_cmd_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .busy_i(busy), .prog_o(prog), .chip_erase_o(chip),
    .sect_erase_o(sect), .lock_en_o(lock), .op_addr_o(op_addr),
    .op_data_o(op_data), .id_mode_o(idm)
  );

  task automatic report(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, bit b = 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; busy = b;
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0;
  endtask

  task automatic expect_cmd(int k, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    exp_t e;
    e.kind = k; e.addr = a; e.data = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check_id(bit e, string tag);
    report(idm == e, tag, "id_mode", int'(idm), int'(e));
  endtask

  task automatic unlock();
    wr(A1, 16'h00AA);
    wr(A2, 16'h0055);
  endtask

  task automatic erase_prefix();
    unlock();
    wr(A1, 16'h0080);
    unlock();
  endtask

  // monitor: pops expected requests as pulses appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        int n;
        int k;
        n = int'(prog) + int'(chip) + int'(sect) + int'(lock);
        k = prog ? K_PROG : chip ? K_CHIP : sect ? K_SECT : K_LOCK;
        if (n > 1) report(0, "R12", "pulse count", n, 1);
        else if (n == 1) begin
          if (q.size() == 0) report(0, "R12", "unexpected pulse kind", k, 0);
          else begin
            exp_t e;
            e = q.pop_front();
            report(k == e.kind, e.tag, "pulse kind", k, e.kind);
            if (e.kind == K_PROG || e.kind == K_SECT)
              report(op_addr == e.addr, e.tag, "op_addr", int'(op_addr), int'(e.addr));
            if (e.kind == K_PROG)
              report(op_data == e.data, e.tag, "op_data", int'(op_data), int'(e.data));
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      report(0, "watchdog", "timeout", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    report({prog, chip, sect, lock, idm} == 5'b0, "R11", "outputs in reset", int'({prog, chip, sect, lock, idm}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    report({prog, chip, sect, lock, idm} == 5'b0, "R11", "outputs after reset", int'({prog, chip, sect, lock, idm}), 0);

    // R2: word program
    unlock(); wr(A1, 16'h00A0);
    expect_cmd(K_PROG, 18'h12345, 16'hBEEF, "R2");
    wr(18'h12345, 16'hBEEF);

    // R8: junk in upper byte of command cycles
    wr(A1, 16'h12AA); wr(A2, 16'hFF55); wr(A1, 16'h34A0);
    expect_cmd(K_PROG, 18'h00010, 16'h5A3C, "R8");
    wr(18'h00010, 16'h5A3C);

    // R3: chip erase
    erase_prefix();
    expect_cmd(K_CHIP, '0, '0, "R3");
    wr(A1, 16'h0010);
    // R3: code 10 at wrong address issues nothing
    erase_prefix(); wr(18'h00100, 16'h0010);
    // R3: unknown sixth code
    erase_prefix(); wr(A1, 16'h0020);

    // R4: sector erase at two addresses, one with upper-byte junk (R8)
    erase_prefix();
    expect_cmd(K_SECT, 18'h03123, '0, "R4");
    wr(18'h03123, 16'h0030);
    erase_prefix();
    expect_cmd(K_SECT, 18'h1F000, '0, "R4");
    wr(18'h1F000, 16'hAB30);

    // R5: lockout enable, and 40 at wrong address does nothing
    erase_prefix();
    expect_cmd(K_LOCK, '0, '0, "R5");
    wr(A1, 16'h0040);
    erase_prefix(); wr(A2, 16'h0040);

    // R1: broken unlocks
    wr(A1, 16'h00AA); wr(A2, 16'h0056); wr(A1, 16'h00A0); wr(18'h00200, 16'h1111);
    wr(18'h05554, 16'h00AA); wr(A2, 16'h0055); wr(A1, 16'h00A0); wr(18'h00200, 16'h2222);
    wr(A1, 16'h00AA); wr(18'h02AAB, 16'h0055); wr(A1, 16'h0080);

    // R6: id entry persists
    unlock(); wr(A1, 16'h0090);
    check_id(1, "R6");
    wr(18'h00040, 16'h1234);
    check_id(1, "R6");

    // R10: F0 in step two is not an exit
    wr(A1, 16'h00AA); wr(A2, 16'h00F0);
    check_id(1, "R10");

    // R9: busy F0 in idle does not exit
    wr(18'h00002, 16'h00F0, 1);
    check_id(1, "R9");

    // R7: single-cycle exit at any address
    wr(18'h00002, 16'h00F0);
    check_id(0, "R7");

    // R7: three-cycle exit
    unlock(); wr(A1, 16'h0090);
    check_id(1, "R6");
    unlock(); wr(A1, 16'h00F0);
    check_id(0, "R7");

    // R10: repeated AA is a mismatch, not a restart
    wr(A1, 16'h00AA); wr(A1, 16'h00AA); wr(A2, 16'h0055); wr(A1, 16'h00A0); wr(18'h00300, 16'h3333);

    // R9: busy writes inside a program sequence leave it intact
    unlock();
    wr(18'h00777, 16'h00F0, 1);
    wr(A1, 16'h0011, 1);
    wr(A1, 16'h00A0);
    expect_cmd(K_PROG, 18'h2ABCD, 16'hC0DE, "R9");
    wr(18'h2ABCD, 16'hC0DE);

    // R9: a whole sequence under busy is ignored
    wr(A1, 16'h00AA, 1); wr(A2, 16'h0055, 1); wr(A1, 16'h00A0, 1); wr(18'h00400, 16'h4444, 1);
    wr(18'h00400, 16'h4444);

    repeat (4) @(negedge clk);
    report(q.size() == 0, "R12", "expected requests left", q.size(), 0);
    done = 1;
    finish_run();
  end

endmodule